// File: doc/BRIEF.md
# Serial Status Flag Controller

This block keeps the status flags of an asynchronous serial port that can carry an extra multiprocessor bit in each character. The receiver and transmitter cores give it single-cycle event strobes: a character has arrived (with its byte, its parity verdict and its multiprocessor bit), the transmitter has taken the byte from the transmit data register, and the last bit of a character has left the line. A CPU register port reads and writes a status register and the transmit data register and reads the receive data register. A DMA engine writes the transmit data register through a separate strobe.

Software clears the three event flags with a two-step handshake. A read must first return the flag as 1, and only then does a later write of 0 to that bit clear it. A parity error still loads the byte into the receive data register, but it raises the parity-error flag in place of the receive-full flag. Reception then stays blocked until software clears the parity error. All inputs are strobes or levels sampled on each clock. No stream here needs back-pressure, so the block has no valid/ready pairs and every event is taken in the cycle it is presented.

Top module: `ser_flag_ctrl`

## Requirements
- R1: After reset, parity error = 0, transmit end = 1, received multiprocessor bit = 0, multiprocessor transmit bit = 0, receive full = 0, transmit empty = 1, and both data registers = 0.
- R2: A `rx_done` strobe taken while not inhibited and without `rx_parity_err` loads `rx_byte` into the receive data register and `rx_mp_bit` into the received multiprocessor bit, and sets receive full on the next edge.
- R3: A `rx_done` strobe taken while not inhibited and with `rx_parity_err` loads the byte and the multiprocessor bit, sets parity error, and leaves receive full unchanged.
- R4: `rx_inhibit_o` is 1 while parity error is 1 or `rx_en` is 0. A `rx_done` strobe during inhibit changes neither data register, nor the received multiprocessor bit, nor any flag, so parity error and the received multiprocessor bit hold while `rx_en` is low.
- R5: Status bits 3 (parity error), 4 (receive full) and 5 (transmit empty) are cleared by a status write (address 0) with that bit 0, but only if a status read since the flag last became 1 returned it as 1. Each such write consumes the arming. A write of 0 without that read, or a write of 1, leaves the flag unchanged.
- R6: A set event in the same cycle as a qualifying clear write leaves the flag at 1.
- R7: `tx_end_o` reads 1 whenever `tx_en` is 0. With `tx_en` = 1 it becomes 1 after a `tx_last_bit` strobe that arrives while transmit empty is 1, and stays unchanged after one that arrives while transmit empty is 0.
- R8: A qualifying clear of transmit empty (R5), or a `dma_tdr_wr` strobe, clears transmit end. `dma_tdr_wr` also clears transmit empty and loads `dma_tdr_data` into the transmit data register, taking priority over a CPU write to address 1.
- R9: A `tx_take` strobe sets transmit empty, and it wins over a DMA clear in the same cycle.
- R10: Status bit 0 is the multiprocessor transmit bit. A status write sets it and it drives `mp_tx_o`. Bits 1 (received multiprocessor bit) and 2 (transmit end) are read-only, and writes to them have no effect.
- R11: `cpu_rdata` returns the status register at address 0 (bits 0 to 5 as above, upper bits 0), the transmit data register at address 1 and the receive data register at address 2. A CPU write to address 1 loads the transmit data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| cpu_rd | input | 1 | CPU read strobe |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_addr | input | 2 | Register select: 0 status, 1 transmit data, 2 receive data |
| cpu_wdata | input | DW | CPU write data |
| cpu_rdata | output | DW | CPU read data for the selected register |
| dma_tdr_wr | input | 1 | DMA write strobe to the transmit data register |
| dma_tdr_data | input | DW | DMA write data |
| rx_done | input | 1 | Receiver has finished a character |
| rx_parity_err | input | 1 | Parity check failed for this character |
| rx_mp_bit | input | 1 | Received multiprocessor bit |
| rx_byte | input | DW | Received character |
| tx_last_bit | input | 1 | Transmitter has sent the last bit of a character |
| tx_take | input | 1 | Transmitter has taken the transmit data register |
| perr_o | output | 1 | Parity-error flag |
| tx_end_o | output | 1 | Transmit-end flag |
| mp_rx_o | output | 1 | Received multiprocessor bit |
| tdr_empty_o | output | 1 | Transmit-data-empty flag |
| rdr_full_o | output | 1 | Receive-data-full flag |
| rx_inhibit_o | output | 1 | Reception blocked |
| mp_tx_o | output | 1 | Multiprocessor bit to append to transmitted characters |
| tdr_o | output | DW | Transmit data register |
| rdr_o | output | DW | Receive data register |

## Verification
The checker watches every cycle for the strobe-to-flag links. An accepted character must raise receive full or parity error one edge later. An inhibited strobe must leave the receive data register alone. Transmit end must be 1 while the transmitter is disabled. A DMA write must empty-clear the transmit flag, a take must set it, and parity error may fall only after a status write of 0. The read-then-write arming, set-over-clear collisions, read-only status bits and the read data layout depend on command sequences. Those are shown only by the bench scenarios, compared against a behavioural model on every clock.

// File: rtl/ser_flag_pkg.sv
package ser_flag_pkg;

  // status register bit positions (software decodes these)
  localparam int B_MPT  = 0;
  localparam int B_MPR  = 1;
  localparam int B_TEND = 2;
  localparam int B_PER  = 3;
  localparam int B_RDF  = 4;
  localparam int B_TDRE = 5;
  localparam int STAT_W = 6;

  // index of the write-zero-to-clear flags; status bit = B_PER + index
  localparam int F_PER  = 0;
  localparam int F_RDF  = 1;
  localparam int F_TDRE = 2;
  localparam int NFLAG  = 3;

  typedef enum logic [1:0] {
    A_STAT = 2'd0,
    A_TDR  = 2'd1,
    A_RDR  = 2'd2,
    A_NONE = 2'd3
  } reg_addr_e;

endpackage

// File: rtl/ser_flag_w0c.sv
// One event flag cleared by software only after it was read as 1.
module ser_flag_w0c #(
  parameter bit RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,      // event from a core, wins over any clear
  input  logic clr_ext_i,  // hardware clear (DMA)
  input  logic rd_i,       // status register read this cycle
  input  logic wr_i,       // status register write this cycle
  input  logic wbit_i,     // written value of this flag's bit
  output logic flag_o,
  output logic qclr_o      // qualifying software clear this cycle
);

  logic flag_q;
  logic arm_q;
  logic wr_zero;

  assign wr_zero = wr_i & ~wbit_i;
  assign qclr_o  = wr_zero & arm_q;
  assign flag_o  = flag_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= RST_VAL;
      arm_q  <= 1'b0;
    end else begin
      flag_q <= set_i | (flag_q & ~qclr_o & ~clr_ext_i);
      // armed by a read that returns 1, consumed by any write of 0,
      // dropped whenever the flag is 0
      arm_q  <= flag_q & (arm_q | rd_i) & ~wr_zero;
    end
  end

endmodule

// File: rtl/ser_flag_rx.sv
// Receive data register and received multiprocessor bit.
module ser_flag_rx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_i,
  input  logic [DW-1:0] byte_i,
  input  logic          mpb_i,
  output logic [DW-1:0] rdr_o,
  output logic          mpb_o
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdr_o <= '0;
      mpb_o <= 1'b0;
    end else if (accept_i) begin
      rdr_o <= byte_i;
      mpb_o <= mpb_i;
    end
  end

endmodule

// File: rtl/ser_flag_tx.sv
// Transmit-end flag and transmit data register.
module ser_flag_tx #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en_i,
  input  logic          last_bit_i,
  input  logic          tdre_i,
  input  logic          tdre_qclr_i,
  input  logic          dma_wr_i,
  input  logic [DW-1:0] dma_data_i,
  input  logic          cpu_wr_i,
  input  logic [DW-1:0] cpu_data_i,
  output logic          tend_o,
  output logic [DW-1:0] tdr_o
);

  logic tend_q;
  logic tend_set;
  logic tend_clr;

  assign tend_set = ~tx_en_i | (last_bit_i & tdre_i);
  assign tend_clr = tdre_qclr_i | dma_wr_i;
  assign tend_o   = tend_q | ~tx_en_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tend_q <= 1'b1;
      tdr_o  <= '0;
    end else begin
      tend_q <= tend_set | (tend_q & ~tend_clr);
      if (dma_wr_i)      tdr_o <= dma_data_i;
      else if (cpu_wr_i) tdr_o <= cpu_data_i;
    end
  end

endmodule

// File: rtl/ser_flag_ctrl.sv
module ser_flag_ctrl
  import ser_flag_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tx_en,
  input  logic          rx_en,
  input  logic          cpu_rd,
  input  logic          cpu_wr,
  input  logic [1:0]    cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  input  logic          dma_tdr_wr,
  input  logic [DW-1:0] dma_tdr_data,
  input  logic          rx_done,
  input  logic          rx_parity_err,
  input  logic          rx_mp_bit,
  input  logic [DW-1:0] rx_byte,
  input  logic          tx_last_bit,
  input  logic          tx_take,
  output logic          perr_o,
  output logic          tx_end_o,
  output logic          mp_rx_o,
  output logic          tdr_empty_o,
  output logic          rdr_full_o,
  output logic          rx_inhibit_o,
  output logic          mp_tx_o,
  output logic [DW-1:0] tdr_o,
  output logic [DW-1:0] rdr_o
);

  localparam logic [NFLAG-1:0] TDRE_SEL = NFLAG'(1) << F_TDRE;

  logic             st_rd;
  logic             st_wr;
  logic             tdr_wr;
  logic             rx_acc;
  logic [NFLAG-1:0] fset;
  logic [NFLAG-1:0] fclr;
  logic [NFLAG-1:0] fq;
  logic [NFLAG-1:0] fqclr;
  logic             mpt_q;

  assign st_rd  = cpu_rd & (cpu_addr == A_STAT);
  assign st_wr  = cpu_wr & (cpu_addr == A_STAT);
  assign tdr_wr = cpu_wr & (cpu_addr == A_TDR);

  assign rx_inhibit_o = fq[F_PER] | ~rx_en;
  assign rx_acc       = rx_done & ~rx_inhibit_o;

  assign fset[F_PER]  = rx_acc & rx_parity_err;
  assign fset[F_RDF]  = rx_acc & ~rx_parity_err;
  assign fset[F_TDRE] = tx_take;
  assign fclr[F_PER]  = 1'b0;
  assign fclr[F_RDF]  = 1'b0;
  assign fclr[F_TDRE] = dma_tdr_wr;

  for (genvar gi = 0; gi < NFLAG; gi++) begin : g_flag
    ser_flag_w0c #(.RST_VAL(gi == F_TDRE)) u_flag (
      .clk       (clk),
      .rst_n     (rst_n),
      .set_i     (fset[gi]),
      .clr_ext_i (fclr[gi]),
      .rd_i      (st_rd),
      .wr_i      (st_wr),
      .wbit_i    (cpu_wdata[B_PER+gi]),
      .flag_o    (fq[gi]),
      .qclr_o    (fqclr[gi])
    );
  end

  assign perr_o      = fq[F_PER];
  assign rdr_full_o  = fq[F_RDF];
  assign tdr_empty_o = fq[F_TDRE];

  ser_flag_rx #(.DW(DW)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept_i (rx_acc),
    .byte_i   (rx_byte),
    .mpb_i    (rx_mp_bit),
    .rdr_o    (rdr_o),
    .mpb_o    (mp_rx_o)
  );

  ser_flag_tx #(.DW(DW)) u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .tx_en_i     (tx_en),
    .last_bit_i  (tx_last_bit),
    .tdre_i      (fq[F_TDRE]),
    .tdre_qclr_i (|(fqclr & TDRE_SEL)),
    .dma_wr_i    (dma_tdr_wr),
    .dma_data_i  (dma_tdr_data),
    .cpu_wr_i    (tdr_wr),
    .cpu_data_i  (cpu_wdata),
    .tend_o      (tx_end_o),
    .tdr_o       (tdr_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mpt_q <= 1'b0;
    else if (st_wr) mpt_q <= cpu_wdata[B_MPT];
  end
  assign mp_tx_o = mpt_q;

  always_comb begin
    cpu_rdata = '0;
    unique case (cpu_addr)
      A_STAT: begin
        cpu_rdata[B_MPT]  = mpt_q;
        cpu_rdata[B_MPR]  = mp_rx_o;
        cpu_rdata[B_TEND] = tx_end_o;
        cpu_rdata[B_PER]  = fq[F_PER];
        cpu_rdata[B_RDF]  = fq[F_RDF];
        cpu_rdata[B_TDRE] = fq[F_TDRE];
      end
      A_TDR:   cpu_rdata = tdr_o;
      A_RDR:   cpu_rdata = rdr_o;
      default: cpu_rdata = '0;
    endcase
  end

endmodule

// File: rtl/ser_flag_chk.sv
module ser_flag_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tx_en,
  input logic          cpu_wr,
  input logic [1:0]    cpu_addr,
  input logic          wbit_per,
  input logic          dma_tdr_wr,
  input logic          rx_done,
  input logic          rx_parity_err,
  input logic          tx_take,
  input logic          perr_o,
  input logic          tx_end_o,
  input logic          tdr_empty_o,
  input logic          rdr_full_o,
  input logic          rx_inhibit_o,
  input logic [DW-1:0] rdr_o
);

  assert_rx_ok_sets_full_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_inhibit_o && !rx_parity_err |=> rdr_full_o);

  assert_rx_bad_sets_perr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && !rx_inhibit_o && rx_parity_err |=> perr_o);

  assert_inhibit_keeps_rdr_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done && rx_inhibit_o |=> $stable(rdr_o));

  assert_perr_falls_on_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(perr_o) |-> $past(cpu_wr && cpu_addr == 2'd0 && !wbit_per));

  assert_tend_when_disabled_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> tx_end_o);

  assert_dma_empties_tdr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    dma_tdr_wr && !tx_take |=> !tdr_empty_o);

  assert_take_sets_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_take |=> tdr_empty_o);

endmodule

bind ser_flag_ctrl ser_flag_chk #(.DW(DW)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .tx_en         (tx_en),
  .cpu_wr        (cpu_wr),
  .cpu_addr      (cpu_addr),
  .wbit_per      (cpu_wdata[3]),
  .dma_tdr_wr    (dma_tdr_wr),
  .rx_done       (rx_done),
  .rx_parity_err (rx_parity_err),
  .tx_take       (tx_take),
  .perr_o        (perr_o),
  .tx_end_o      (tx_end_o),
  .tdr_empty_o   (tdr_empty_o),
  .rdr_full_o    (rdr_full_o),
  .rx_inhibit_o  (rx_inhibit_o),
  .rdr_o         (rdr_o)
);

// File: tb/sim_ser_flag_ctrl.sv
`timescale 1ns/1ps
module sim_ser_flag_ctrl;

  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tx_en = 1'b0, rx_en = 1'b0;
  logic          cpu_rd = 1'b0, cpu_wr = 1'b0;
  logic [1:0]    cpu_addr = 2'd0;
  logic [DW-1:0] cpu_wdata = '0;
  logic [DW-1:0] cpu_rdata;
  logic          dma_tdr_wr = 1'b0;
  logic [DW-1:0] dma_tdr_data = '0;
  logic          rx_done = 1'b0, rx_parity_err = 1'b0, rx_mp_bit = 1'b0;
  logic [DW-1:0] rx_byte = '0;
  logic          tx_last_bit = 1'b0, tx_take = 1'b0;
  logic          perr_o, tx_end_o, mp_rx_o, tdr_empty_o, rdr_full_o;
  logic          rx_inhibit_o, mp_tx_o;
  logic [DW-1:0] tdr_o, rdr_o;

  int nchk = 0;
  int nerr = 0;

  always #10 clk = ~clk;

  ser_flag_ctrl #(.DW(DW)) u0 (.*);

  // behavioural reference model
  bit m_per, m_rdf, m_tdre, m_tend, m_mpb, m_mpt;
  bit a_per, a_rdf, a_tdre;
  logic [DW-1:0] m_rdr, m_tdr;

  always @(posedge clk) begin : model
    bit srd, swr, acc, q_per, q_rdf, q_tdre;
    if (!rst_n) begin
      m_per = 0; m_rdf = 0; m_tdre = 1; m_tend = 1; m_mpb = 0; m_mpt = 0;
      a_per = 0; a_rdf = 0; a_tdre = 0; m_rdr = '0; m_tdr = '0;
    end else begin
      srd    = cpu_rd && cpu_addr == 2'd0;
      swr    = cpu_wr && cpu_addr == 2'd0;
      acc    = rx_done && !(m_per || !rx_en);
      q_per  = swr && !cpu_wdata[3] && a_per;
      q_rdf  = swr && !cpu_wdata[4] && a_rdf;
      q_tdre = swr && !cpu_wdata[5] && a_tdre;
      a_per  = m_per  && (a_per  || srd) && !(swr && !cpu_wdata[3]);
      a_rdf  = m_rdf  && (a_rdf  || srd) && !(swr && !cpu_wdata[4]);
      a_tdre = m_tdre && (a_tdre || srd) && !(swr && !cpu_wdata[5]);
      if (!tx_en || (tx_last_bit && m_tdre)) m_tend = 1;
      else if (q_tdre || dma_tdr_wr)         m_tend = 0;
      if (acc && rx_parity_err) m_per = 1; else if (q_per) m_per = 0;
      if (acc && !rx_parity_err) m_rdf = 1; else if (q_rdf) m_rdf = 0;
      if (tx_take) m_tdre = 1; else if (q_tdre || dma_tdr_wr) m_tdre = 0;
      if (acc) begin m_rdr = rx_byte; m_mpb = rx_mp_bit; end
      if (dma_tdr_wr) m_tdr = dma_tdr_data;
      else if (cpu_wr && cpu_addr == 2'd1) m_tdr = cpu_wdata;
      if (swr) m_mpt = cpu_wdata[0];
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R3 model perr", perr_o, m_per);
      chk("R2 model rdr_full", rdr_full_o, m_rdf);
      chk("R9 model tdr_empty", tdr_empty_o, m_tdre);
      chk("R7 model tx_end", tx_end_o, m_tend || !tx_en);
      chk("R4 model inhibit", rx_inhibit_o, m_per || !rx_en);
      chk("R2 model mp_rx", mp_rx_o, m_mpb);
      chk("R10 model mp_tx", mp_tx_o, m_mpt);
      chk("R2 model rdr", rdr_o, m_rdr);
      chk("R8 model tdr", tdr_o, m_tdr);
    end
  end

  task automatic tick();
    @(posedge clk);
    #3;
    cpu_rd = 0; cpu_wr = 0; dma_tdr_wr = 0; rx_done = 0;
    rx_parity_err = 0; tx_last_bit = 0; tx_take = 0;
  endtask

  task automatic st_write(input logic [DW-1:0] v);
    cpu_wr = 1; cpu_addr = 2'd0; cpu_wdata = v; tick();
  endtask

  task automatic st_read();
    cpu_rd = 1; cpu_addr = 2'd0; tick();
  endtask

  task automatic rx_char(input logic [DW-1:0] b, input bit perr, input bit mpb);
    rx_done = 1; rx_byte = b; rx_parity_err = perr; rx_mp_bit = mpb;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    #1;
    // R1 reset state
    chk("R1 perr", perr_o, 0);
    chk("R1 tx_end", tx_end_o, 1);
    chk("R1 mp_rx", mp_rx_o, 0);
    chk("R1 mp_tx", mp_tx_o, 0);
    chk("R1 rdr_full", rdr_full_o, 0);
    chk("R1 tdr_empty", tdr_empty_o, 1);
    chk("R1 rdr", rdr_o, 0);
    chk("R4 inhibit with rx_en low", rx_inhibit_o, 1);

    rx_en = 1; tick();
    chk("R4 inhibit released", rx_inhibit_o, 0);

    rx_char(8'hA5, 0, 1); tick();
    chk("R2 rdr_full set", rdr_full_o, 1);
    chk("R2 rdr loaded", rdr_o, 8'hA5);
    chk("R2 mpb captured", mp_rx_o, 1);

    st_write(8'h00);
    chk("R5 unarmed write keeps rdr_full", rdr_full_o, 1);
    chk("R5 unarmed write keeps tdr_empty", tdr_empty_o, 1);

    cpu_rd = 1; cpu_addr = 2'd0; #1;
    chk("R11 status layout", cpu_rdata, 8'h36);
    tick();

    st_write(8'h20);
    chk("R5 armed write clears rdr_full", rdr_full_o, 0);
    chk("R5 write of one keeps tdr_empty", tdr_empty_o, 1);

    rx_char(8'h3C, 1, 0); tick();
    chk("R3 perr set", perr_o, 1);
    chk("R3 rdr loaded on parity error", rdr_o, 8'h3C);
    chk("R3 rdr_full untouched", rdr_full_o, 0);
    chk("R4 inhibit on perr", rx_inhibit_o, 1);

    rx_char(8'h77, 0, 1); tick();
    chk("R4 blocked rdr", rdr_o, 8'h3C);
    chk("R4 blocked rdr_full", rdr_full_o, 0);
    chk("R4 blocked mpb", mp_rx_o, 0);

    st_read(); st_write(8'h20);
    chk("R5 perr cleared", perr_o, 0);
    chk("R4 inhibit drops", rx_inhibit_o, 0);

    rx_en = 0; rx_char(8'h11, 0, 1); tick();
    chk("R4 rx_en low blocks rdr", rdr_o, 8'h3C);
    chk("R4 rx_en low blocks rdr_full", rdr_full_o, 0);
    rx_en = 1;

    chk("R7 tx_end with tx_en low", tx_end_o, 1);
    tx_en = 1; tick();
    chk("R7 tx_end after enable", tx_end_o, 1);
    st_read(); st_write(8'h00);
    chk("R8 tdre clear empties", tdr_empty_o, 0);
    chk("R8 tdre clear ends tx_end", tx_end_o, 0);

    tx_last_bit = 1; tick();
    chk("R7 last bit with tdre low", tx_end_o, 0);
    tx_take = 1; tick();
    chk("R9 take sets tdr_empty", tdr_empty_o, 1);
    tx_last_bit = 1; tick();
    chk("R7 last bit with tdre high", tx_end_o, 1);

    dma_tdr_wr = 1; dma_tdr_data = 8'h5A;
    cpu_wr = 1; cpu_addr = 2'd1; cpu_wdata = 8'hEE; tick();
    chk("R8 dma empties", tdr_empty_o, 0);
    chk("R8 dma clears tx_end", tx_end_o, 0);
    chk("R8 dma data wins", tdr_o, 8'h5A);

    tx_take = 1; dma_tdr_wr = 1; dma_tdr_data = 8'h5B; tick();
    chk("R9 take wins over dma", tdr_empty_o, 1);

    rx_char(8'h42, 0, 0); tick();
    st_read();
    cpu_wr = 1; cpu_addr = 2'd0; cpu_wdata = 8'h20;
    rx_char(8'h43, 0, 1); tick();
    chk("R6 set beats clear", rdr_full_o, 1);
    chk("R6 byte taken", rdr_o, 8'h43);
    st_write(8'h20);
    chk("R5 arming consumed", rdr_full_o, 1);

    st_write(8'h25);
    chk("R10 mpt written", mp_tx_o, 1);
    chk("R10 mp_rx read-only", mp_rx_o, 1);
    st_read(); st_write(8'h05);
    chk("R10 tx_end read-only", tx_end_o, 0);

    cpu_wr = 1; cpu_addr = 2'd1; cpu_wdata = 8'h99; tick();
    chk("R11 cpu tdr write", tdr_o, 8'h99);
    cpu_addr = 2'd2; #1;
    chk("R11 rdr readback", cpu_rdata, 8'h43);
    cpu_addr = 2'd1; #1;
    chk("R11 tdr readback", cpu_rdata, 8'h99);
    tick(); tick();
    finish_run();
  end

endmodule